// File: doc/BRIEF.md
# Serial Debug Command Responder

This block is the target end of a word-level background-debug link. A host moves one 16-bit word into the block per transfer. During the same transfer the block returns one 17-bit response word: a status bit followed by 16 data bits. Every response belongs to the word received in the transfer before it, so the command stream and the response stream run one transfer apart.

The block decodes three kinds of word. A no-operation command is acknowledged. A register-read command reads one of sixteen 32-bit core registers through a combinational select and returns the value as two result words. A memory-read command takes two further address words, then issues a request on a request/acknowledge memory port and returns the read data once the port answers. Register reads are refused with a bus-error response unless the core is halted. Words that match no command return an illegal-command response. While a memory access is outstanding, every transfer returns a not-ready response.

The bit-level serial shifter and the processor core are not part of the block. A one-cycle transfer strobe with a command word stands in for the shifter, and a level input stands in for the core's halted state.

Top module: `dbgr_responder`

## Requirements
- R1: Response bit 16 is the status bit. It is 0 for normal data. It is 1 only together with one of three data codes: 0x0000 for not-ready, 0xFFFF for an illegal command and 0x0001 for a bus error.
- R2: After reset the response presented for the first transfer is not-ready (0x10000), and no memory request is active.
- R3: A word with bits [15:12]=0x2 and bits [11:4]=0 is a register read. Bits [3:0] drive the register select; bit 3 chooses address (1) or data (0) registers and bits [2:0] pick one of eight. The next transfer returns the upper 16 bits of the value with status 0, and the word it carries is ignored. The transfer after that returns the lower 16 bits, and the word it carries is decoded as a command.
- R4: A register read received while the halted input is low gets a bus-error response (0x10001) in the next transfer, and the word carried by that transfer is decoded as a command.
- R5: A word with bits [15:12]=0x1, bits [11:6]=0, bits [3:0]=0 and a size field in bits [5:4] (0 byte, 1 word, 2 long) is a memory read. The next two transfers carry the high and low address words, and both return not-ready. After the low-address transfer, the memory request rises with address {high,low} and the size code.
- R6: Every transfer that occurs while the memory request is pending returns not-ready. The word it carries changes neither the request nor the address.
- R7: When the memory port acknowledges without error, a long read returns the upper and then the lower 16 data bits in the next two transfers, and the word carried by the upper-half transfer is ignored. A word read returns data bits [15:0] in one transfer. A byte read returns data bits [7:0] in the low byte of one transfer, with status 0. The word carried by the transfer that returns the last result is decoded as a command.
- R8: An acknowledge that carries an error returns a single bus-error response (0x10001). The word carried by that transfer is decoded as a command.
- R9: Any other word, including a memory read with size field 3, gets an illegal-command response (0x1FFFF) in the next transfer. The word carried by that transfer is decoded as a command.
- R10: The all-zero word is a no-operation and gets a completion response of 0x0FFFF.
- R11: Once raised, the memory request stays high with a stable address and size until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halted | input | 1 | Core is halted |
| xfer_go | input | 1 | One-cycle strobe marking a transfer |
| xfer_cmd | input | 16 | Word received in this transfer |
| rsp_word | output | 17 | Response returned in this transfer (status bit 16) |
| reg_sel | output | 4 | Register select, {addr/data, number} |
| reg_rdata | input | 32 | Selected register value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_size | output | 2 | Access size code |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory access finished |
| mem_err | input | 1 | Access ended in bus error (with ack) |

## Verification
A vector table runs the halted-core command stream. It mixes no-ops, address and data register reads, and several illegal words: an unknown opcode, a register read with stray middle bits, a nonzero word in the no-op opcode and a memory read of size 3. Placing an illegal word in the position after a register read shows whether the ignored upper-half transfer is really skipped. Directed tests then run long, word and byte memory reads with zero and multi-cycle latency and transfers during the wait. They also cover an errored acknowledge, a register read on a running core and a reset in the middle of a command. Together these separate a correct one-transfer lag from off-by-one response timing and from mistaking ignored words for commands.

// File: rtl/dbgr_pkg.sv
package dbgr_pkg;

   localparam int unsigned RSP_W = 17;

   localparam logic [RSP_W-1:0] RSP_NOT_READY = 17'h1_0000;
   localparam logic [RSP_W-1:0] RSP_ILLEGAL   = 17'h1_FFFF;
   localparam logic [RSP_W-1:0] RSP_BUS_ERR   = 17'h1_0001;
   localparam logic [RSP_W-1:0] RSP_DONE      = 17'h0_FFFF;

   localparam logic [3:0] OPC_MEM_RD = 4'h1;
   localparam logic [3:0] OPC_REG_RD = 4'h2;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_WORD = 2'd1;
   localparam logic [1:0] SZ_LONG = 2'd2;

   typedef enum logic [1:0] {
      K_NOP,
      K_REG,
      K_MEM,
      K_ILL
   } cmd_kind_e;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_SKIP,
      ST_AHI,
      ST_ALO,
      ST_WAIT
   } seq_state_e;

endpackage

// File: rtl/dbgr_decode.sv
module dbgr_decode
   import dbgr_pkg::*;
#(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned SEL_W  = 4
) (
   input  logic [WORD_W-1:0] word,
   output cmd_kind_e         kind,
   output logic [SEL_W-1:0]  sel,
   output logic [1:0]        size
);

   localparam int unsigned OPC_LSB = WORD_W - 4;

   initial begin
      if (WORD_W != 16) $error("dbgr_decode: command layout needs WORD_W of 16");
      if (SEL_W != 4)   $error("dbgr_decode: register select must be 4 bits");
   end

   logic [3:0] opc;
   logic       reg_mid_zero;
   logic       mem_pad_zero;

   assign opc          = word[WORD_W-1:OPC_LSB];
   assign reg_mid_zero = (word[OPC_LSB-1:SEL_W] == '0);
   assign mem_pad_zero = (word[OPC_LSB-1:6] == '0) && (word[3:0] == '0);
   assign sel          = word[SEL_W-1:0];
   assign size         = word[5:4];

   always_comb begin
      kind = K_ILL;
      if (word == '0)
         kind = K_NOP;
      else if (opc == OPC_REG_RD && reg_mid_zero)
         kind = K_REG;
      else if (opc == OPC_MEM_RD && mem_pad_zero && size != 2'b11)
         kind = K_MEM;
   end

endmodule

// File: rtl/dbgr_mem_port.sv
module dbgr_mem_port #(
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word,
   input  logic              size_we,
   input  logic [1:0]        size_in,
   input  logic              hi_we,
   input  logic              lo_we,
   input  logic              mem_ack,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size
);

   localparam int unsigned HI_W = ADDR_W - WORD_W;

   initial begin
      if (ADDR_W <= WORD_W || ADDR_W > 2 * WORD_W)
         $error("dbgr_mem_port: ADDR_W must lie above one word and at most two");
   end

   logic [HI_W-1:0]   hi_q;
   logic [WORD_W-1:0] lo_q;
   logic [1:0]        size_q;
   logic              req_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         size_q <= '0;
         req_q  <= 1'b0;
      end else begin
         if (size_we && !req_q) size_q <= size_in;
         if (hi_we && !req_q)   hi_q   <= word[HI_W-1:0];
         if (lo_we && !req_q) begin
            lo_q  <= word;
            req_q <= 1'b1;
         end else if (req_q && mem_ack) begin
            req_q <= 1'b0;
         end
      end
   end

   assign mem_req  = req_q;
   assign mem_addr = {hi_q, lo_q};
   assign mem_size = size_q;

   // R11: request held with a stable address and size until acknowledged
   assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_size)));

   // R5: a request only starts right after the low-address transfer
   assert_req_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(lo_we));

endmodule

// File: rtl/dbgr_rsp_fmt.sv
module dbgr_rsp_fmt
   import dbgr_pkg::*;
#(
   parameter int unsigned WORD_W         = 16,
   parameter bit          BYTE_ZERO_FILL = 1'b1
) (
   input  logic [2*WORD_W-1:0] rdata,
   input  logic [1:0]          size,
   output logic [WORD_W-1:0]   first,
   output logic [WORD_W-1:0]   second,
   output logic                two_words
);

   localparam int unsigned BYTE_W = 8;

   logic [WORD_W-BYTE_W-1:0] upper_fill;

   generate
      if (BYTE_ZERO_FILL) begin : g_zero_fill
         assign upper_fill = '0;
      end else begin : g_raw_fill
         assign upper_fill = rdata[WORD_W-1:BYTE_W];
      end
   endgenerate

   always_comb begin
      two_words = 1'b0;
      second    = rdata[WORD_W-1:0];
      unique case (size)
         SZ_LONG: begin
            first     = rdata[2*WORD_W-1:WORD_W];
            two_words = 1'b1;
         end
         SZ_WORD: first = rdata[WORD_W-1:0];
         default: first = {upper_fill, rdata[BYTE_W-1:0]};
      endcase
   end

endmodule

// File: rtl/dbgr_seq.sv
module dbgr_seq
   import dbgr_pkg::*;
#(
   parameter int unsigned WORD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                halted,
   input  logic                xfer_go,
   input  cmd_kind_e           kind,
   input  logic [2*WORD_W-1:0] reg_rdata,
   input  logic                mem_ack,
   input  logic                mem_err,
   input  logic [WORD_W-1:0]   res_first,
   input  logic [WORD_W-1:0]   res_second,
   input  logic                res_two,
   output logic                size_we,
   output logic                hi_we,
   output logic                lo_we,
   output logic [RSP_W-1:0]    rsp
);

   initial begin
      if (WORD_W + 1 != RSP_W) $error("dbgr_seq: response must be one word plus status");
   end

   seq_state_e          st_q;
   logic [RSP_W-1:0]    rsp_q;
   logic [WORD_W-1:0]   lo_q;

   assign size_we = xfer_go && (st_q == ST_CMD) && (kind == K_MEM);
   assign hi_we   = xfer_go && (st_q == ST_AHI);
   assign lo_we   = xfer_go && (st_q == ST_ALO);
   assign rsp     = rsp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_CMD;
         rsp_q <= RSP_NOT_READY;
         lo_q  <= '0;
      end else if (st_q == ST_WAIT && mem_ack) begin
         if (mem_err) begin
            rsp_q <= RSP_BUS_ERR;
            st_q  <= ST_CMD;
         end else begin
            rsp_q <= {1'b0, res_first};
            lo_q  <= res_second;
            st_q  <= res_two ? ST_SKIP : ST_CMD;
         end
      end else if (xfer_go) begin
         unique case (st_q)
            ST_CMD: begin
               unique case (kind)
                  K_NOP: rsp_q <= RSP_DONE;
                  K_REG: begin
                     if (halted) begin
                        rsp_q <= {1'b0, reg_rdata[2*WORD_W-1:WORD_W]};
                        lo_q  <= reg_rdata[WORD_W-1:0];
                        st_q  <= ST_SKIP;
                     end else begin
                        rsp_q <= RSP_BUS_ERR;
                     end
                  end
                  K_MEM: begin
                     rsp_q <= RSP_NOT_READY;
                     st_q  <= ST_AHI;
                  end
                  default: rsp_q <= RSP_ILLEGAL;
               endcase
            end
            ST_SKIP: begin
               rsp_q <= {1'b0, lo_q};
               st_q  <= ST_CMD;
            end
            ST_AHI: begin
               rsp_q <= RSP_NOT_READY;
               st_q  <= ST_ALO;
            end
            ST_ALO: begin
               rsp_q <= RSP_NOT_READY;
               st_q  <= ST_WAIT;
            end
            default: ;
         endcase
      end
   end

   logic seen_go_q;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_go_q <= 1'b0;
      else if (xfer_go) seen_go_q <= 1'b1;
   end

   // R1: status set only with one of the three reserved codes
   assert_status_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp[WORD_W] |-> (rsp[WORD_W-1:0] == 16'h0000 || rsp[WORD_W-1:0] == 16'hFFFF
                       || rsp[WORD_W-1:0] == 16'h0001));

   // R2: until the first transfer the response is not-ready
   assert_first_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_go_q |-> (rsp == RSP_NOT_READY));

   // R4: register read on a running core answers with a bus error
   assert_run_berr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_go && st_q == ST_CMD && kind == K_REG && !halted) |=> (rsp == RSP_BUS_ERR));

   // R6: while waiting for memory the response stays not-ready
   assert_wait_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT) |-> (rsp == RSP_NOT_READY));

endmodule

// File: rtl/dbgr_responder.sv
module dbgr_responder
   import dbgr_pkg::*;
#(
   parameter int unsigned WORD_W         = 16,
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned SEL_W          = 4,
   parameter bit          BYTE_ZERO_FILL = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                halted,
   input  logic                xfer_go,
   input  logic [WORD_W-1:0]   xfer_cmd,
   output logic [WORD_W:0]     rsp_word,
   output logic [SEL_W-1:0]    reg_sel,
   input  logic [2*WORD_W-1:0] reg_rdata,
   output logic                mem_req,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [1:0]          mem_size,
   input  logic [2*WORD_W-1:0] mem_rdata,
   input  logic                mem_ack,
   input  logic                mem_err
);

   cmd_kind_e         kind;
   logic [1:0]        dec_size;
   logic [WORD_W-1:0] res_first;
   logic [WORD_W-1:0] res_second;
   logic              res_two;
   logic              size_we;
   logic              hi_we;
   logic              lo_we;

   dbgr_decode #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_decode (
      .word (xfer_cmd),
      .kind (kind),
      .sel  (reg_sel),
      .size (dec_size)
   );

   dbgr_mem_port #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .word     (xfer_cmd),
      .size_we  (size_we),
      .size_in  (dec_size),
      .hi_we    (hi_we),
      .lo_we    (lo_we),
      .mem_ack  (mem_ack),
      .mem_req  (mem_req),
      .mem_addr (mem_addr),
      .mem_size (mem_size)
   );

   dbgr_rsp_fmt #(.WORD_W(WORD_W), .BYTE_ZERO_FILL(BYTE_ZERO_FILL)) u_rsp_fmt (
      .rdata     (mem_rdata),
      .size      (mem_size),
      .first     (res_first),
      .second    (res_second),
      .two_words (res_two)
   );

   dbgr_seq #(.WORD_W(WORD_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .halted     (halted),
      .xfer_go    (xfer_go),
      .kind       (kind),
      .reg_rdata  (reg_rdata),
      .mem_ack    (mem_ack),
      .mem_err    (mem_err),
      .res_first  (res_first),
      .res_second (res_second),
      .res_two    (res_two),
      .size_we    (size_we),
      .hi_we      (hi_we),
      .lo_we      (lo_we),
      .rsp        (rsp_word)
   );

endmodule

// File: tb/dbgr_responder_tb.sv
module dbgr_responder_tb;

   localparam logic [16:0] NR   = 17'h1_0000;
   localparam logic [16:0] ILL  = 17'h1_FFFF;
   localparam logic [16:0] BERR = 17'h1_0001;
   localparam logic [16:0] DONE = 17'h0_FFFF;
   localparam int NVEC = 11;

   // {command word, response expected in the same transfer}
   localparam logic [32:0] VEC [NVEC] = '{
      {16'h0000, NR},          // R2 first transfer, R10 NOP sent
      {16'h2009, DONE},        // R10 NOP answered; R3 address reg 1
      {16'hBEEF, 17'h0_C0D9},  // R3 upper half, word ignored
      {16'h2003, 17'h0_5A09},  // R3 lower half, data reg 3 decoded
      {16'h7123, 17'h0_C0D3},  // R3 upper half, illegal word ignored
      {16'h0000, 17'h0_5A03},  // R3 lower half
      {16'h2100, DONE},        // R9 stray middle bits
      {16'h0001, ILL},         // R9 answered; nonzero no-op opcode
      {16'h1030, ILL},         // R9 memory size 3
      {16'h0000, ILL},         // R9 answered
      {16'h0000, DONE}         // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        halted = 1'b1;
   logic        xfer_go = 1'b0;
   logic [15:0] xfer_cmd = '0;
   logic [16:0] rsp_word;
   logic [3:0]  reg_sel;
   logic [31:0] reg_rdata;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [1:0]  mem_size;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;
   logic        mem_err = 1'b0;

   int checks = 0;
   int failures = 0;
   int mem_lat = 0;
   bit err_next = 1'b0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   assign reg_rdata = {12'hC0D, reg_sel, 12'h5A0, reg_sel};

   dbgr_responder u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .halted    (halted),
      .xfer_go   (xfer_go),
      .xfer_cmd  (xfer_cmd),
      .rsp_word  (rsp_word),
      .reg_sel   (reg_sel),
      .reg_rdata (reg_rdata),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_size  (mem_size),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack),
      .mem_err   (mem_err)
   );

   // memory model: answers a request after mem_lat cycles
   always begin
      @(negedge clk);
      if (mem_req) begin
         repeat (mem_lat) @(negedge clk);
         mem_rdata = mem_addr ^ 32'hF0F0_0F0F;
         mem_err   = err_next;
         mem_ack   = 1'b1;
         @(negedge clk);
         mem_ack   = 1'b0;
         mem_err   = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // check the response of this transfer, then perform it
   task automatic xfer(input logic [15:0] w, input logic [16:0] exp,
                       input logic [16:0] mask, input string req);
      chk((rsp_word & mask) == (exp & mask), req, {15'd0, rsp_word}, {15'd0, exp});
      xfer_cmd = w;
      xfer_go  = 1'b1;
      @(negedge clk);
      xfer_go  = 1'b0;
   endtask

   task automatic wait_mem();
      while (mem_req) @(negedge clk);
   endtask

   initial begin
      #400000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2 reset state
      chk(rsp_word == NR, "R2 reset response", {15'd0, rsp_word}, {15'd0, NR});
      chk(mem_req == 1'b0, "R2 reset request", {31'd0, mem_req}, 32'd0);

      // R3 R9 R10 R1 table walk
      for (int i = 0; i < NVEC; i++)
         xfer(VEC[i][32:17], VEC[i][16:0], 17'h1FFFF, "R3/R9/R10 table");

      // R4 register read on a running core
      halted = 1'b0;
      xfer(16'h2005, DONE, 17'h1FFFF, "R10");
      xfer(16'h0000, BERR, 17'h1FFFF, "R4 bus error");
      xfer(16'h0000, DONE, 17'h1FFFF, "R4 next word decoded");
      halted = 1'b1;

      // R5 R6 R7 long read, latency 5
      mem_lat = 5;
      xfer(16'h1020, DONE, 17'h1FFFF, "R10");
      xfer(16'h1234, NR, 17'h1FFFF, "R5 high address");
      xfer(16'h5678, NR, 17'h1FFFF, "R5 low address");
      chk(mem_req == 1'b1, "R5 request raised", {31'd0, mem_req}, 32'd1);
      chk(mem_addr == 32'h1234_5678, "R5 address", mem_addr, 32'h1234_5678);
      chk(mem_size == 2'd2, "R5 size", {30'd0, mem_size}, 32'd2);
      xfer(16'hAAAA, NR, 17'h1FFFF, "R6 pending");
      xfer(16'h2001, NR, 17'h1FFFF, "R6 pending");
      chk(mem_addr == 32'h1234_5678, "R6 address kept", mem_addr, 32'h1234_5678);
      chk(mem_req == 1'b1, "R11 request held", {31'd0, mem_req}, 32'd1);
      wait_mem();
      xfer(16'h7777, 17'h0_E2C4, 17'h1FFFF, "R7 long upper");
      xfer(16'h0000, 17'h0_5977, 17'h1FFFF, "R7 long lower");
      xfer(16'h0000, DONE, 17'h1FFFF, "R7 last word decoded");

      // R7 word read, zero latency
      mem_lat = 0;
      xfer(16'h1010, DONE, 17'h1FFFF, "R10");
      xfer(16'h0000, NR, 17'h1FFFF, "R5 high address");
      xfer(16'h0100, NR, 17'h1FFFF, "R5 low address");
      chk(mem_size == 2'd1, "R5 word size", {30'd0, mem_size}, 32'd1);
      wait_mem();
      xfer(16'h0000, 17'h0_0E0F, 17'h1FFFF, "R7 word");
      xfer(16'h0000, DONE, 17'h1FFFF, "R7 word next decoded");

      // R7 byte read
      mem_lat = 2;
      xfer(16'h1000, DONE, 17'h1FFFF, "R10");
      xfer(16'hABCD, NR, 17'h1FFFF, "R5 high address");
      xfer(16'h0003, NR, 17'h1FFFF, "R5 low address");
      chk(mem_size == 2'd0, "R5 byte size", {30'd0, mem_size}, 32'd0);
      wait_mem();
      xfer(16'h0000, 17'h0_000C, 17'h100FF, "R7 byte");
      xfer(16'h0000, DONE, 17'h1FFFF, "R7 byte next decoded");

      // R8 errored acknowledge
      mem_lat = 1;
      err_next = 1'b1;
      xfer(16'h1020, DONE, 17'h1FFFF, "R10");
      xfer(16'h1111, NR, 17'h1FFFF, "R5 high address");
      xfer(16'h2222, NR, 17'h1FFFF, "R5 low address");
      wait_mem();
      err_next = 1'b0;
      xfer(16'h0000, BERR, 17'h1FFFF, "R8 bus error");
      xfer(16'h0000, DONE, 17'h1FFFF, "R8 next word decoded");

      // R2 reset in the middle of a register read
      xfer(16'h200A, DONE, 17'h1FFFF, "R10");
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk(rsp_word == NR, "R2 reset mid command", {15'd0, rsp_word}, {15'd0, NR});
      xfer(16'h0000, NR, 17'h1FFFF, "R2 first after reset");
      xfer(16'h0000, DONE, 17'h1FFFF, "R10");

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule